// File: doc/BRIEF.md
# Interrupt Destination Mask Decoder

This block turns the addressing fields of an interrupt message into the set of agents that must receive it. It handles a pool of agents, whose size is a parameter. Each agent has a fixed physical ID equal to its index. Each agent also supplies two values: an 8-bit logical ID, and a 4-bit code that selects its logical-addressing model. One model is flat: the logical ID is a bitmap. The other is cluster: the upper nibble names a cluster, and the lower nibble is a bitmap inside that cluster.

A request carries four inputs:

- the 32-bit command word, which holds the shorthand, the addressing mode and the delivery mode;
- a separate 8-bit destination;
- the ID of the sending agent;
- a strobe.

One clock later the block presents three results together: the target mask, a one-hot single target for lowest-priority delivery, and a flag that marks an empty lowest-priority request. The results hold until the next strobe. Choosing among the targets by priority is left to a later stage.

Top module: `irq_dest_decoder`

## Requirements
- R1: In physical mode, destination 0xFF sets every bit of the target mask.
- R2: In physical mode, any other destination selects only the agent whose index equals it. A destination at or above the agent count selects none.
- R3: In logical mode, an agent with model code 0xF is selected when the destination ANDed with its logical ID is nonzero.
- R4: In logical mode, an agent with model code 0x0 is selected when two conditions hold: the destination's upper nibble equals its logical ID's upper nibble, and the lower nibbles share a set bit.
- R5: In logical mode, an agent with any model code other than 0x0 or 0xF is never selected.
- R6: Shorthand 1 selects only the sender, whatever the destination and mode.
- R7: Shorthand 2 selects all agents.
- R8: Shorthand 3 selects all agents except the sender. Shorthand 0 uses the decoded destination.
- R9: The block takes the shorthand from command bits [19:18], the mode from bit 11 (0 physical, 1 logical) and the delivery type from bits [10:8]. No other command bit has an effect.
- R10: When the delivery type is 3'b001 (lowest priority), the one-hot output marks the lowest-numbered agent in the target mask.
- R11: For lowest-priority delivery with an empty mask, the one-hot output is zero and the none flag is 1. For any other delivery type, both are zero.
- R12: All outputs are zero after reset. They update exactly one cycle after a strobe, with the valid output high for that one cycle, and they hold while no strobe arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_cmd | input | 32 | Command word carrying the shorthand, the mode and the delivery type |
| req_dest | input | 8 | Destination field |
| req_sender | input | SID_W | Index of the sending agent |
| agent_lid | input | N_AGENTS*8 | Logical ID of each agent; agent i occupies bits [8i+7:8i] |
| agent_model | input | N_AGENTS*4 | Addressing model code of each agent; agent i occupies bits [4i+3:4i] |
| resp_valid | output | 1 | High for one cycle when the results update |
| target_mask | output | N_AGENTS | One bit for each selected agent |
| lowpri_onehot | output | N_AGENTS | Single target for lowest-priority delivery |
| lowpri_none | output | 1 | Lowest-priority request with no target |

## Verification
A shorthand override and the lowest-priority pick can act on the same request. The pick then has to run on the mask after the shorthand has been applied, not on the decoded destination. The bench provokes this in two cases:

- all-except-self sent by agent 0, so the pick must move to agent 1;
- self-only sent by a high-numbered agent, so the pick must land on the sender even though the destination decodes to lower-numbered agents.

A scoreboard model computes the mask from the requirements and derives the pick from that mask. It then compares the mask, the one-hot output and the none flag of each response against the model.

// File: rtl/irq_dest_pkg.sv
package irq_dest_pkg;

    typedef enum logic [1:0] {
        SH_DEST   = 2'd0,
        SH_SELF   = 2'd1,
        SH_ALL    = 2'd2,
        SH_OTHERS = 2'd3
    } shorthand_e;

    localparam logic [2:0] DLV_LOWEST   = 3'd1;
    localparam logic [3:0] MODEL_FLAT   = 4'hF;
    localparam logic [3:0] MODEL_CLUSTER = 4'h0;
    localparam logic [7:0] DEST_BCAST   = 8'hFF;

    typedef struct packed {
        logic [7:0] dest;
        logic       logical;
        shorthand_e sh;
        logic [2:0] dlv;
    } msg_t;

    function automatic msg_t unpack_msg(input logic [31:0] cmd, input logic [7:0] dest);
        msg_t m;
        m.dest    = dest;
        m.logical = cmd[11];
        m.sh      = shorthand_e'(cmd[19:18]);
        m.dlv     = cmd[10:8];
        return m;
    endfunction

    function automatic logic logical_hit(input logic [7:0] dest,
                                         input logic [7:0] lid,
                                         input logic [3:0] model);
        logic hit;
        case (model)
            MODEL_FLAT:    hit = |(dest & lid);
            MODEL_CLUSTER: hit = (dest[7:4] == lid[7:4]) && (|(dest[3:0] & lid[3:0]));
            default:       hit = 1'b0;
        endcase
        return hit;
    endfunction

endpackage

// File: rtl/irq_dest_match.sv
module irq_dest_match
    import irq_dest_pkg::*;
#(
    parameter int N_AGENTS = 16
) (
    input  msg_t                   msg,
    input  logic [N_AGENTS*8-1:0]  agent_lid,
    input  logic [N_AGENTS*4-1:0]  agent_model,
    output logic [N_AGENTS-1:0]    addr_mask
);
    for (genvar i = 0; i < N_AGENTS; i++) begin : g_agent
        logic phys_hit;
        logic log_hit;
        assign phys_hit = (msg.dest == DEST_BCAST) || (32'(msg.dest) == i);
        assign log_hit  = logical_hit(msg.dest, agent_lid[i*8 +: 8], agent_model[i*4 +: 4]);
        assign addr_mask[i] = msg.logical ? log_hit : phys_hit;
    end
endmodule

// File: rtl/irq_dest_shorthand.sv
module irq_dest_shorthand
    import irq_dest_pkg::*;
#(
    parameter int N_AGENTS = 16,
    parameter int SID_W    = $clog2(N_AGENTS)
) (
    input  shorthand_e             sh,
    input  logic [SID_W-1:0]       sender,
    input  logic [N_AGENTS-1:0]    addr_mask,
    output logic [N_AGENTS-1:0]    sel_mask
);
    for (genvar i = 0; i < N_AGENTS; i++) begin : g_sel
        logic is_self;
        assign is_self = (32'(sender) == i);
        always_comb begin
            case (sh)
                SH_DEST:   sel_mask[i] = addr_mask[i];
                SH_SELF:   sel_mask[i] = is_self;
                SH_ALL:    sel_mask[i] = 1'b1;
                default:   sel_mask[i] = !is_self;
            endcase
        end
    end
endmodule

// File: rtl/irq_lowest_pick.sv
module irq_lowest_pick #(
    parameter int N_AGENTS = 16
) (
    input  logic [N_AGENTS-1:0] mask,
    output logic [N_AGENTS-1:0] onehot,
    output logic                none
);
    // Isolate the least significant set bit with the two's complement trick.
    assign onehot = mask & (~mask + N_AGENTS'(1));
    assign none   = ~|mask;
endmodule

// File: rtl/irq_dest_decoder.sv
module irq_dest_decoder
    import irq_dest_pkg::*;
#(
    parameter int N_AGENTS = 16,
    parameter int SID_W    = $clog2(N_AGENTS)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   req_valid,
    input  logic [31:0]            req_cmd,
    input  logic [7:0]             req_dest,
    input  logic [SID_W-1:0]       req_sender,
    input  logic [N_AGENTS*8-1:0]  agent_lid,
    input  logic [N_AGENTS*4-1:0]  agent_model,
    output logic                   resp_valid,
    output logic [N_AGENTS-1:0]    target_mask,
    output logic [N_AGENTS-1:0]    lowpri_onehot,
    output logic                   lowpri_none
);
    msg_t                msg;
    logic [N_AGENTS-1:0] addr_mask;
    logic [N_AGENTS-1:0] sel_mask;
    logic [N_AGENTS-1:0] pick_onehot;
    logic                pick_none;
    logic                is_lowest;

    assign msg       = unpack_msg(req_cmd, req_dest);
    assign is_lowest = (msg.dlv == DLV_LOWEST);

    irq_dest_match #(.N_AGENTS(N_AGENTS)) u_match (
        .msg         (msg),
        .agent_lid   (agent_lid),
        .agent_model (agent_model),
        .addr_mask   (addr_mask)
    );

    irq_dest_shorthand #(.N_AGENTS(N_AGENTS), .SID_W(SID_W)) u_sh (
        .sh        (msg.sh),
        .sender    (req_sender),
        .addr_mask (addr_mask),
        .sel_mask  (sel_mask)
    );

    irq_lowest_pick #(.N_AGENTS(N_AGENTS)) u_pick (
        .mask   (sel_mask),
        .onehot (pick_onehot),
        .none   (pick_none)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            resp_valid    <= 1'b0;
            target_mask   <= '0;
            lowpri_onehot <= '0;
            lowpri_none   <= 1'b0;
        end else begin
            resp_valid <= req_valid;
            if (req_valid) begin
                target_mask   <= sel_mask;
                lowpri_onehot <= is_lowest ? pick_onehot : '0;
                lowpri_none   <= is_lowest && pick_none;
            end
        end
    end

    // Single target is at most one agent and always inside the mask.
    assert_pick_onehot_R10: assert property (@(posedge clk) disable iff (rst)
        resp_valid |-> $onehot0(lowpri_onehot));
    assert_pick_in_mask_R10: assert property (@(posedge clk) disable iff (rst)
        resp_valid |-> ((lowpri_onehot & ~target_mask) == '0));
    assert_pick_lowest_R10: assert property (@(posedge clk) disable iff (rst)
        (lowpri_onehot != '0) |-> (((lowpri_onehot - N_AGENTS'(1)) & target_mask) == '0));
    assert_none_empty_R11: assert property (@(posedge clk) disable iff (rst)
        lowpri_none |-> (target_mask == '0 && lowpri_onehot == '0));
    assert_self_only_R6: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_cmd[19:18] == 2'd1) |=>
        (target_mask == (N_AGENTS'(1) << $past(req_sender))));
    assert_others_skip_R8: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_cmd[19:18] == 2'd3) |=> !target_mask[$past(req_sender)]);
    assert_hold_R12: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> ($stable(target_mask) && !resp_valid));
endmodule

// File: tb/sim_irq_dest_decoder.sv
module sim_irq_dest_decoder;
    localparam int N  = 16;
    localparam int SW = $clog2(N);
    localparam logic [31:0] JUNK = 32'h9235_70AB & ~32'h000C_0F00;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic [31:0]   req_cmd = '0;
    logic [7:0]    req_dest = '0;
    logic [SW-1:0] req_sender = '0;
    logic [N*8-1:0] agent_lid;
    logic [N*4-1:0] agent_model;
    logic          resp_valid;
    logic [N-1:0]  target_mask;
    logic [N-1:0]  lowpri_onehot;
    logic          lowpri_none;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    typedef struct {
        logic [N-1:0] mask;
        logic [N-1:0] one;
        logic         none;
        string        tag;
    } exp_t;
    exp_t q[$];
    exp_t last_exp;

    always #5 clk = ~clk;

    irq_dest_decoder #(.N_AGENTS(N)) u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_cmd(req_cmd),
        .req_dest(req_dest), .req_sender(req_sender), .agent_lid(agent_lid),
        .agent_model(agent_model), .resp_valid(resp_valid),
        .target_mask(target_mask), .lowpri_onehot(lowpri_onehot),
        .lowpri_none(lowpri_none)
    );

    // Agents 0-7 flat with one-hot IDs, 8-11 cluster 2, 12-13 cluster 3,
    // 14 an unsupported model with ID 0xFF, 15 flat with ID 0.
    initial begin
        for (int i = 0; i < N; i++) begin
            if (i < 8) begin
                agent_lid[i*8 +: 8] = 8'(1 << i); agent_model[i*4 +: 4] = 4'hF;
            end else if (i < 12) begin
                agent_lid[i*8 +: 8] = {4'h2, 4'(1 << (i-8))}; agent_model[i*4 +: 4] = 4'h0;
            end else if (i < 14) begin
                agent_lid[i*8 +: 8] = {4'h3, 4'(1 << (i-12))}; agent_model[i*4 +: 4] = 4'h0;
            end else if (i == 14) begin
                agent_lid[i*8 +: 8] = 8'hFF; agent_model[i*4 +: 4] = 4'h5;
            end else begin
                agent_lid[i*8 +: 8] = 8'h00; agent_model[i*4 +: 4] = 4'hF;
            end
        end
    end

    function automatic logic [31:0] mk_cmd(input logic [1:0] sh, input logic lg, input logic [2:0] dlv);
        return JUNK | (32'(sh) << 18) | (32'(lg) << 11) | (32'(dlv) << 8);
    endfunction

    function automatic exp_t model(input logic [1:0] sh, input logic lg, input logic [2:0] dlv,
                                   input logic [7:0] dest, input int snd, input string tag);
        exp_t e;
        e.mask = '0; e.one = '0; e.none = 1'b0; e.tag = tag;
        for (int i = 0; i < N; i++) begin
            logic [7:0] lid;
            logic [3:0] md;
            logic hit;
            lid = agent_lid[i*8 +: 8];
            md  = agent_model[i*4 +: 4];
            if (!lg) hit = (dest == 8'hFF) || (int'(dest) == i);
            else if (md == 4'hF) hit = (dest & lid) != 0;
            else if (md == 4'h0) hit = (dest[7:4] == lid[7:4]) && ((dest[3:0] & lid[3:0]) != 0);
            else hit = 1'b0;
            case (sh)
                2'd0: e.mask[i] = hit;
                2'd1: e.mask[i] = (i == snd);
                2'd2: e.mask[i] = 1'b1;
                default: e.mask[i] = (i != snd);
            endcase
        end
        if (dlv == 3'd1) begin
            e.none = (e.mask == '0);
            for (int i = N-1; i >= 0; i--) if (e.mask[i]) e.one = N'(1) << i;
        end
        return e;
    endfunction

    task automatic send(input logic [1:0] sh, input logic lg, input logic [2:0] dlv,
                        input logic [7:0] dest, input int snd, input string tag);
        req_cmd    = mk_cmd(sh, lg, dlv);
        req_dest   = dest;
        req_sender = SW'(snd);
        req_valid  = 1'b1;
        q.push_back(model(sh, lg, dlv, dest, snd, tag));
        @(negedge clk);
        req_valid  = 1'b0;
    endtask

    task automatic compare(input exp_t e);
        checks++;
        if (target_mask !== e.mask || lowpri_onehot !== e.one || lowpri_none !== e.none) begin
            errors++;
            $display("FAIL %s actual mask=%h one=%h none=%b expected mask=%h one=%h none=%b",
                     e.tag, target_mask, lowpri_onehot, lowpri_none, e.mask, e.one, e.none);
        end
    endtask

    // Monitor: pops the scoreboard whenever a result is presented.
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && resp_valid) begin
                if (q.size() == 0) begin
                    checks++; errors++;
                    $display("FAIL R12 actual=unexpected response expected=none");
                end else begin
                    last_exp = q.pop_front();
                    compare(last_exp);
                end
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        checks++;
        if (resp_valid !== 1'b0 || target_mask !== '0 || lowpri_onehot !== '0 || lowpri_none !== 1'b0) begin
            errors++;
            $display("FAIL R12 reset actual valid=%b mask=%h expected valid=0 mask=0", resp_valid, target_mask);
        end
        send(2'd0, 1'b0, 3'd0, 8'hFF, 3, "R1 physical broadcast");
        send(2'd0, 1'b0, 3'd0, 8'h05, 3, "R2 physical id 5");
        send(2'd0, 1'b0, 3'd0, 8'h14, 3, "R2 physical id out of range");
        send(2'd0, 1'b1, 3'd0, 8'h05, 3, "R3 flat logical");
        send(2'd0, 1'b1, 3'd0, 8'h23, 3, "R4 cluster logical");
        send(2'd0, 1'b1, 3'd0, 8'hFF, 3, "R5 unsupported model never hit");
        send(2'd1, 1'b0, 3'd0, 8'hFF, 7, "R6 self only");
        send(2'd2, 1'b1, 3'd0, 8'h00, 7, "R7 all");
        send(2'd3, 1'b0, 3'd0, 8'h00, 0, "R8 all except sender");
        send(2'd0, 1'b0, 3'd0, 8'h01, 2, "R9 mode bit physical");
        send(2'd0, 1'b1, 3'd0, 8'h01, 2, "R9 mode bit logical");
        send(2'd0, 1'b1, 3'd1, 8'h26, 2, "R10 lowest priority pick");
        send(2'd3, 1'b0, 3'd1, 8'h00, 0, "R10 R8 pick after excluding sender");
        send(2'd1, 1'b1, 3'd1, 8'h03, 9, "R10 R6 pick is sender");
        send(2'd0, 1'b0, 3'd1, 8'h40, 2, "R11 empty lowest priority");
        send(2'd0, 1'b0, 3'd2, 8'hFF, 2, "R11 non-lowest gives no pick");
        repeat (4) @(negedge clk);
        checks++;
        if (resp_valid !== 1'b0 || target_mask !== last_exp.mask || lowpri_onehot !== last_exp.one) begin
            errors++;
            $display("FAIL R12 hold actual mask=%h valid=%b expected mask=%h valid=0",
                     target_mask, resp_valid, last_exp.mask);
        end
        if (q.size() != 0) begin
            checks++; errors++;
            $display("FAIL R12 actual pending=%0d expected pending=0", q.size());
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL R12 watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule